// File: doc/BRIEF.md
# Floating-Point Compare with Exception Flags

This block compares two single-precision IEEE 754 operands and reports the result as a four-bit condition code in N,Z,C,V order. Software chooses a quiet or a signalling compare. Either kind can also compare the first operand against positive zero. Each operand is classified as a quiet NaN, a signalling NaN, a subnormal, a zero or another value. That class, the compare kind and two mode bits (default-NaN handling and flush-to-zero) decide what happens to the request. It either completes in hardware, or it sets a sticky invalid-operation flag and possibly raises a trap request, or it is handed to support software through a bounce request.

A request is presented for one cycle with `req_valid`. The decision appears one clock edge later on the registered outputs. Every accepted request produces exactly one one-cycle pulse: `cc_wr` when a condition code was written, `trap_req` for an invalid-operation trap, or `bounce_req` for a software bounce. The condition code holds its last written value between writes. The sticky invalid flag (bit 0 of the status register) and the input-exception flag (bit 7 of the exception register) are held by the block and cleared only by their write ports. The operand field widths are parameters and default to single precision.

Top module: `fcmp_flags_unit`

## Requirements
- R1: After reset, `nzcv` is 0000 and `bounce_req`, `trap_req`, `cc_wr`, `inv_sticky` and `inp_exc` are all 0.
- R2: An ordered compare without a NaN, and without a subnormal when flush-to-zero is off, pulses `cc_wr` one cycle after the request. It writes `nzcv` = 1000 for less, 0110 for equal and 0010 for greater. Positive and negative zero compare equal.
- R3: With default-NaN mode off, a NaN in either operand raises `bounce_req` and sets `inp_exc`, for both compare kinds. `nzcv` keeps its value and `inv_sticky` is not set.
- R4: With default-NaN mode on, a quiet compare whose NaN operands are all quiet writes `nzcv` = 0011 (unordered). It does not set `inv_sticky` and does not trap.
- R5: With default-NaN mode on, a signalling NaN in a quiet compare, or any NaN in a signalling compare (`cmp_signal` = 1), sets `inv_sticky`. If `trap_en` is 1, it pulses `trap_req` and leaves `nzcv` unchanged. Otherwise it writes 0011.
- R6: With flush-to-zero off, a request with a subnormal operand and no NaN raises `bounce_req` and sets `inp_exc` instead of writing a result.
- R7: With flush-to-zero on, a subnormal operand is compared as a zero of its own sign.
- R8: With `cmp_zero` = 1, `op_b` is ignored and the first operand is compared against positive zero.
- R9: `inv_sticky` changes only when it is set by an invalid case or written through `stat_wr`. `inp_exc` changes only when it is set by a bounce or written through `exc_wr`. When a set and a write hit the same cycle, the set wins.
- R10: An operand is a NaN when its exponent is all ones and its fraction is nonzero. The NaN is quiet when fraction bit 22 is 1 and signalling when that bit is 0. It is subnormal when its exponent is zero and its fraction is nonzero. Infinities are ordered values.
- R11: A cycle without `req_valid` produces no pulse and leaves `nzcv` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Compare request, one cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| cmp_signal | input | 1 | 1 selects the signalling compare kind |
| cmp_zero | input | 1 | 1 compares `op_a` against positive zero |
| dn_mode | input | 1 | Default-NaN mode |
| ftz_mode | input | 1 | Flush-to-zero mode |
| trap_en | input | 1 | Invalid-operation trap enable (status bit 8) |
| stat_wr | input | 1 | Write strobe for the sticky invalid flag |
| stat_wval | input | 1 | Value written to the sticky invalid flag |
| exc_wr | input | 1 | Write strobe for the input-exception flag |
| exc_wval | input | 1 | Value written to the input-exception flag |
| nzcv | output | 4 | Last written condition code, N,Z,C,V |
| cc_wr | output | 1 | Pulse: condition code written |
| trap_req | output | 1 | Pulse: invalid-operation trap request |
| bounce_req | output | 1 | Pulse: support-software bounce request |
| inv_sticky | output | 1 | Sticky invalid-operation flag (status bit 0) |
| inp_exc | output | 1 | Input-exception flag (exception bit 7) |

## Verification
The bench builds the block with its default widths: an 8-bit exponent and a 23-bit fraction. With these widths, random picks of exponent and fraction reach every operand class: zero, subnormal, normal, infinity, quiet NaN and signalling NaN. Normal operands are drawn from a few exponents and fractions, so equal, mirrored and opposite-sign pairs come up often. Random mode bits and random writes to the two flags cover every combination of compare kind, NaN kind and mode, including a flag write that lands in the same cycle as a flag set.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    localparam logic [3:0] CC_LT = 4'b1000;
    localparam logic [3:0] CC_EQ = 4'b0110;
    localparam logic [3:0] CC_GT = 4'b0010;
    localparam logic [3:0] CC_UN = 4'b0011;

    typedef enum logic [1:0] {
        ORD_LT = 2'd0,
        ORD_EQ = 2'd1,
        ORD_GT = 2'd2
    } ord_e;

    typedef enum logic [1:0] {
        ACT_CC_ORD = 2'd0,
        ACT_CC_UN  = 2'd1,
        ACT_BOUNCE = 2'd2,
        ACT_TRAP   = 2'd3
    } act_e;

    typedef struct packed {
        logic nan;
        logic snan;
        logic sub;
        logic zero;
    } cls_t;

    typedef struct packed {
        act_e act;
        logic set_inv;
    } verdict_t;

    function automatic logic [3:0] ord_to_cc(ord_e o);
        case (o)
            ORD_LT:  return CC_LT;
            ORD_EQ:  return CC_EQ;
            ORD_GT:  return CC_GT;
            default: return CC_UN;
        endcase
    endfunction

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
    import fcmp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0] opnd,
    input  logic         ftz,
    output cls_t         cls,
    output logic         sign_o,
    output logic [W-2:0] mag_o
);
    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;
    logic exp_ones, exp_zero, frac_nz;

    assign expo     = opnd[W-2:FRAC_W];
    assign frac     = opnd[FRAC_W-1:0];
    assign exp_ones = &expo;
    assign exp_zero = ~|expo;
    assign frac_nz  = |frac;

    always_comb begin
        cls.nan  = exp_ones && frac_nz;
        cls.snan = exp_ones && frac_nz && !frac[FRAC_W-1];
        cls.sub  = exp_zero && frac_nz;
        cls.zero = exp_zero && !frac_nz;
        sign_o   = opnd[W-1];
        mag_o    = (cls.sub && ftz) ? '0 : opnd[W-2:0];
    end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
    import fcmp_pkg::*;
#(
    parameter int MW = 31
) (
    input  logic          sign_a,
    input  logic [MW-1:0] mag_a,
    input  logic          sign_b,
    input  logic [MW-1:0] mag_b,
    output ord_e          ord
);
    logic both_zero, a_big;

    assign both_zero = (mag_a == '0) && (mag_b == '0);
    assign a_big     = mag_a > mag_b;

    always_comb begin
        if (both_zero || (sign_a == sign_b && mag_a == mag_b))
            ord = ORD_EQ;
        else if (sign_a != sign_b)
            ord = sign_a ? ORD_LT : ORD_GT;
        else
            ord = (a_big ^ sign_a) ? ORD_GT : ORD_LT;
    end
endmodule

// File: rtl/fcmp_policy.sv
module fcmp_policy
    import fcmp_pkg::*;
(
    input  cls_t     cls_a,
    input  cls_t     cls_b,
    input  logic     signalling,
    input  logic     dn,
    input  logic     ftz,
    input  logic     trap_en,
    output verdict_t verdict
);
    logic any_nan, any_snan, any_sub;

    assign any_nan  = cls_a.nan  | cls_b.nan;
    assign any_snan = cls_a.snan | cls_b.snan;
    assign any_sub  = cls_a.sub  | cls_b.sub;

    always_comb begin
        verdict.act     = ACT_CC_ORD;
        verdict.set_inv = 1'b0;
        if (any_nan) begin
            if (!dn) begin
                verdict.act = ACT_BOUNCE;
            end else if (signalling || any_snan) begin
                verdict.set_inv = 1'b1;
                verdict.act     = trap_en ? ACT_TRAP : ACT_CC_UN;
            end else begin
                verdict.act = ACT_CC_UN;
            end
        end else if (any_sub && !ftz) begin
            verdict.act = ACT_BOUNCE;
        end
    end
endmodule

// File: rtl/fcmp_flags_unit.sv
module fcmp_flags_unit
    import fcmp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         req_valid,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         cmp_signal,
    input  logic         cmp_zero,
    input  logic         dn_mode,
    input  logic         ftz_mode,
    input  logic         trap_en,
    input  logic         stat_wr,
    input  logic         stat_wval,
    input  logic         exc_wr,
    input  logic         exc_wval,
    output logic [3:0]   nzcv,
    output logic         cc_wr,
    output logic         trap_req,
    output logic         bounce_req,
    output logic         inv_sticky,
    output logic         inp_exc
);
    localparam int NOPS = 2;

    logic [W-1:0] opnd  [NOPS];
    cls_t         cls   [NOPS];
    logic         sgn   [NOPS];
    logic [W-2:0] mag   [NOPS];
    ord_e         ord;
    verdict_t     verdict;

    assign opnd[0] = op_a;
    assign opnd[1] = cmp_zero ? '0 : op_b;

    for (genvar gi = 0; gi < NOPS; gi++) begin : g_opnd
        fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_cls (
            .opnd   (opnd[gi]),
            .ftz    (ftz_mode),
            .cls    (cls[gi]),
            .sign_o (sgn[gi]),
            .mag_o  (mag[gi])
        );
    end

    fcmp_order #(.MW(W-1)) i_order (
        .sign_a (sgn[0]),
        .mag_a  (mag[0]),
        .sign_b (sgn[1]),
        .mag_b  (mag[1]),
        .ord    (ord)
    );

    fcmp_policy i_policy (
        .cls_a      (cls[0]),
        .cls_b      (cls[1]),
        .signalling (cmp_signal),
        .dn         (dn_mode),
        .ftz        (ftz_mode),
        .trap_en    (trap_en),
        .verdict    (verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            nzcv       <= 4'b0000;
            cc_wr      <= 1'b0;
            trap_req   <= 1'b0;
            bounce_req <= 1'b0;
            inv_sticky <= 1'b0;
            inp_exc    <= 1'b0;
        end else begin
            cc_wr      <= req_valid && (verdict.act == ACT_CC_ORD || verdict.act == ACT_CC_UN);
            trap_req   <= req_valid && (verdict.act == ACT_TRAP);
            bounce_req <= req_valid && (verdict.act == ACT_BOUNCE);

            if (req_valid && verdict.act == ACT_CC_ORD)
                nzcv <= ord_to_cc(ord);
            else if (req_valid && verdict.act == ACT_CC_UN)
                nzcv <= CC_UN;

            if (req_valid && verdict.set_inv)
                inv_sticky <= 1'b1;
            else if (stat_wr)
                inv_sticky <= stat_wval;

            if (req_valid && verdict.act == ACT_BOUNCE)
                inp_exc <= 1'b1;
            else if (exc_wr)
                inp_exc <= exc_wval;
        end
    end
endmodule

// File: rtl/fcmp_flags_chk.sv
module fcmp_flags_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       trap_en,
    input logic       stat_wr,
    input logic       exc_wr,
    input logic [3:0] nzcv,
    input logic       cc_wr,
    input logic       trap_req,
    input logic       bounce_req,
    input logic       inv_sticky,
    input logic       inp_exc
);
    p_one_action_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({bounce_req, trap_req, cc_wr}));

    p_cc_legal_r2: assert property (@(posedge clk) disable iff (rst)
        cc_wr |-> (nzcv == 4'b1000 || nzcv == 4'b0110 || nzcv == 4'b0010 || nzcv == 4'b0011));

    p_bounce_exc_r3: assert property (@(posedge clk) disable iff (rst)
        bounce_req |-> inp_exc);

    p_trap_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> inv_sticky);

    p_trap_gated_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !trap_en) |=> !trap_req);

    p_sticky_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (inv_sticky && !stat_wr) |=> inv_sticky);

    p_exc_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (inp_exc && !exc_wr) |=> inp_exc);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!bounce_req && !trap_req && !cc_wr && $stable(nzcv)));
endmodule

bind fcmp_flags_unit fcmp_flags_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .trap_en    (trap_en),
    .stat_wr    (stat_wr),
    .exc_wr     (exc_wr),
    .nzcv       (nzcv),
    .cc_wr      (cc_wr),
    .trap_req   (trap_req),
    .bounce_req (bounce_req),
    .inv_sticky (inv_sticky),
    .inp_exc    (inp_exc)
);

// File: tb/test_fcmp_flags_unit.sv
module test_fcmp_flags_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic        cmp_signal = 1'b0, cmp_zero = 1'b0, dn_mode = 1'b0, ftz_mode = 1'b0, trap_en = 1'b0;
    logic        stat_wr = 1'b0, stat_wval = 1'b0, exc_wr = 1'b0, exc_wval = 1'b0;
    logic [3:0]  nzcv;
    logic        cc_wr, trap_req, bounce_req, inv_sticky, inp_exc;

    int n_run = 0;
    int n_fail = 0;

    logic [3:0] m_nzcv = 4'b0000;
    logic       m_inv = 1'b0;
    logic       m_exc = 1'b0;

    always #5 clk = ~clk;

    fcmp_flags_unit i_fcmp_flags_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .op_a(op_a), .op_b(op_b),
        .cmp_signal(cmp_signal), .cmp_zero(cmp_zero), .dn_mode(dn_mode),
        .ftz_mode(ftz_mode), .trap_en(trap_en), .stat_wr(stat_wr), .stat_wval(stat_wval),
        .exc_wr(exc_wr), .exc_wval(exc_wval), .nzcv(nzcv), .cc_wr(cc_wr),
        .trap_req(trap_req), .bounce_req(bounce_req), .inv_sticky(inv_sticky), .inp_exc(inp_exc)
    );

    typedef struct packed {
        logic       b;
        logic       t;
        logic       c;
        logic [3:0] cc;
        logic       si;
    } exp_t;

    function automatic logic f_nan(logic [31:0] x);
        return x[30:23] == 8'hFF && x[22:0] != 0;
    endfunction
    function automatic logic f_snan(logic [31:0] x);
        return f_nan(x) && !x[22];
    endfunction
    function automatic logic f_sub(logic [31:0] x);
        return x[30:23] == 8'h00 && x[22:0] != 0;
    endfunction
    function automatic longint f_key(logic [31:0] x, logic ftz);
        longint m;
        m = (f_sub(x) && ftz) ? 0 : longint'(x[30:0]);
        return x[31] ? -m : m;
    endfunction

    function automatic exp_t f_expect(logic [31:0] a, logic [31:0] b0, logic sig, logic z,
                                      logic dn, logic ftz, logic te);
        exp_t e;
        logic [31:0] b;
        longint ka, kb;
        e = '0;
        b = z ? 32'h0 : b0;
        if (f_nan(a) || f_nan(b)) begin
            if (!dn) e.b = 1;
            else if (sig || f_snan(a) || f_snan(b)) begin
                e.si = 1;
                if (te) e.t = 1; else begin e.c = 1; e.cc = 4'b0011; end
            end else begin e.c = 1; e.cc = 4'b0011; end
        end else if ((f_sub(a) || f_sub(b)) && !ftz) begin
            e.b = 1;
        end else begin
            ka = f_key(a, ftz);
            kb = f_key(b, ftz);
            e.c = 1;
            e.cc = (ka < kb) ? 4'b1000 : (ka == kb) ? 4'b0110 : 4'b0010;
        end
        return e;
    endfunction

    task automatic check(string tag, string what, logic [3:0] act, logic [3:0] expv);
        n_run++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, expv);
        end
    endtask

    task automatic check_all(string tag, logic eb, logic et, logic ec);
        check(tag, "bounce_req", {3'b0, bounce_req}, {3'b0, eb});
        check(tag, "trap_req",   {3'b0, trap_req},   {3'b0, et});
        check(tag, "cc_wr",      {3'b0, cc_wr},      {3'b0, ec});
        check(tag, "nzcv",       nzcv,               m_nzcv);
        check(tag, "inv_sticky", {3'b0, inv_sticky}, {3'b0, m_inv});
        check(tag, "inp_exc",    {3'b0, inp_exc},    {3'b0, m_exc});
    endtask

    // drive one request at a falling edge, check one cycle later
    task automatic do_op(string tag, logic [31:0] a, logic [31:0] b, logic sig, logic z,
                         logic dn, logic ftz, logic te,
                         logic swr, logic swv, logic ewr, logic ewv);
        exp_t e;
        e = f_expect(a, b, sig, z, dn, ftz, te);
        op_a = a; op_b = b; cmp_signal = sig; cmp_zero = z; dn_mode = dn;
        ftz_mode = ftz; trap_en = te; stat_wr = swr; stat_wval = swv;
        exc_wr = ewr; exc_wval = ewv; req_valid = 1'b1;
        if (e.si) m_inv = 1'b1; else if (swr) m_inv = swv;
        if (e.b)  m_exc = 1'b1; else if (ewr) m_exc = ewv;
        if (e.c)  m_nzcv = e.cc;
        @(negedge clk);
        req_valid = 1'b0; stat_wr = 1'b0; exc_wr = 1'b0;
        check_all(tag, e.b, e.t, e.c);
    endtask

    task automatic do_idle(string tag);
        op_a = $urandom; op_b = 32'h7F800001; dn_mode = 1'b1; cmp_signal = 1'b1;
        trap_en = 1'b1; req_valid = 1'b0;
        @(negedge clk);
        check_all(tag, 1'b0, 1'b0, 1'b0);
    endtask

    function automatic logic [31:0] rnd_op();
        logic [31:0] x;
        int k;
        k = $urandom % 8;
        x[31] = $urandom % 2;
        case (k)
            0: x[30:0] = '0;
            1: x[30:0] = {8'h00, 23'($urandom % 8 + 1)};
            2, 3, 4: x[30:0] = {8'(126 + $urandom % 3), 23'($urandom % 4)};
            5: x[30:0] = {8'hFF, 23'h0};
            6: x[30:0] = {8'hFF, 1'b1, 22'($urandom % 4)};
            default: x[30:0] = {8'hFF, 1'b0, 22'($urandom % 4 + 1)};
        endcase
        return x;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all("R1", 1'b0, 1'b0, 1'b0);

        // R2 ordered results
        do_op("R2", 32'h3F800000, 32'h40000000, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        do_op("R2", 32'h40000000, 32'h40000000, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        do_op("R2", 32'hC0000000, 32'hBF800000, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        do_op("R2", 32'h00000000, 32'h80000000, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        // R10 infinities are ordered
        do_op("R10", 32'h7F800000, 32'h7F800000, 1, 0, 0, 0, 1, 0, 0, 0, 0);
        // R3 NaN with default-NaN off
        do_op("R3", 32'h7FC00000, 32'h3F800000, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        do_op("R3", 32'h3F800000, 32'hFF800001, 1, 0, 0, 1, 1, 0, 0, 0, 0);
        // R4 quiet compare, quiet NaN
        do_op("R4", 32'h7FC00000, 32'h3F800000, 0, 0, 1, 0, 1, 0, 0, 0, 0);
        // R10 snan has fraction msb clear -> R5 path
        do_op("R10", 32'h7F800001, 32'h3F800000, 0, 0, 1, 0, 0, 0, 0, 0, 0);
        do_op("R9", 32'h3F800000, 32'h3F800000, 0, 0, 1, 0, 0, 1, 0, 1, 0);
        do_op("R5", 32'h7F800001, 32'h3F800000, 0, 0, 1, 0, 1, 0, 0, 0, 0);
        do_op("R5", 32'h7FC00000, 32'h3F800000, 1, 0, 1, 0, 0, 1, 0, 0, 0);
        // R9 set wins over same-cycle clear
        do_op("R9", 32'h7FC00000, 32'h00000000, 1, 0, 1, 0, 0, 1, 0, 0, 0);
        // R6 subnormal with ftz off
        do_op("R6", 32'h00000001, 32'h3F800000, 0, 0, 1, 0, 0, 0, 0, 1, 0);
        // R7 flushed subnormal equals negative zero
        do_op("R7", 32'h00000005, 32'h80000000, 0, 0, 1, 1, 0, 0, 0, 0, 0);
        do_op("R7", 32'h80000003, 32'h00000001, 0, 0, 0, 1, 0, 0, 0, 0, 0);
        // R8 op_b ignored under compare-against-zero
        do_op("R8", 32'hBF800000, 32'h7F800001, 1, 1, 0, 0, 1, 0, 0, 0, 0);
        do_op("R8", 32'h00000000, 32'hFF000000, 0, 1, 0, 0, 0, 0, 0, 0, 0);
        do_idle("R11");

        for (int i = 0; i < 600; i++) begin
            if ($urandom % 6 == 0) do_idle("R11");
            do_op("R2-rand", rnd_op(), rnd_op(), 1'($urandom), 1'($urandom % 4 == 0),
                  1'($urandom), 1'($urandom), 1'($urandom),
                  1'($urandom % 5 == 0), 1'($urandom), 1'($urandom % 5 == 0), 1'($urandom));
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule